// File: doc/BRIEF.md
# Iterative Multiply-Divide Unit with HI/LO Result Pair

This block is a sequential 32-bit arithmetic unit. It multiplies or divides two operands, signed or unsigned, and writes the result to two dedicated 32-bit registers, HI and LO. It never writes the general register file. A multiply leaves its 64-bit product split across the pair. A divide leaves the remainder in HI and the quotient in LO.

The unit accepts an operation with a one-cycle start strobe. It spends one setup cycle reducing the operands to magnitudes. It then runs 32 iteration cycles: shift-add for multiply, restoring subtraction for divide. The unit restores the signs and commits HI and LO at the edge that ends the last iteration. Busy is high for that whole window.

Two read ports expose HI and LO. Each port raises a stall while the unit is busy. A requester holds its read until the stall drops, and so always sees the finished result. No overflow or divide-by-zero flag exists; software must check for those conditions.

Top module: `muldiv_hilo`

## Requirements
- R1: With `startOp` = 2'b00 (signed multiply), HI receives bits 63..32 and LO bits 31..0 of the two's-complement product of `opA` and `opB`.
- R2: With `startOp` = 2'b01 (unsigned multiply), HI and LO receive the upper and lower halves of the unsigned 64-bit product.
- R3: With `startOp` = 2'b10 (signed divide) and a nonzero divisor, LO receives the quotient truncated toward zero and HI the remainder, which carries the sign of the dividend. The case 0x80000000 / -1 yields quotient 0x80000000 and remainder 0.
- R4: With `startOp` = 2'b11 (unsigned divide) and a nonzero divisor, LO receives the unsigned quotient and HI the unsigned remainder.
- R5: A start accepted at a clock edge raises `busy` in the next cycle. `busy` stays high for exactly 33 cycles (1 setup + 32 iterations). HI and LO take their new values at the same edge at which `busy` falls.
- R6: A start strobe while `busy` is high is ignored. It does not change the running operation, its timing or its result.
- R7: Division by zero, signed or unsigned, completes in the normal 33 cycles. LO becomes all ones, and HI becomes `opA` unchanged.
- R8: After reset HI and LO are zero and `busy` is low. HI and LO change only when an operation completes.
- R9: `hiRdData` and `loRdData` always show HI and LO. `hiRdStall` is high exactly when `hiRdReq` and `busy` are both high, and `loRdStall` likewise for `loRdReq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Start strobe, taken only while not busy |
| startOp | input | 2 | 00 signed mul, 01 unsigned mul, 10 signed div, 11 unsigned div |
| opA | input | 32 | Multiplicand or dividend |
| opB | input | 32 | Multiplier or divisor |
| busy | output | 1 | Operation in progress |
| hiRdReq | input | 1 | Move-from-HI request |
| loRdReq | input | 1 | Move-from-LO request |
| hiRdData | output | 32 | Current HI value |
| loRdData | output | 32 | Current LO value |
| hiRdStall | output | 1 | HI read must be held |
| loRdStall | output | 1 | LO read must be held |

## Verification
The assertions assume that `startValid`, `startOp` and the operands are stable around the sampling edge. They also assume that the operands matter only in the cycle the start is taken. The bench drives all inputs one nanosecond after each rising edge and changes the operands freely at other times. Read requests are toggled at random every cycle, independent of the start sequence. Some starts are deliberately aimed into the busy window to confirm they leave no trace.

// File: rtl/mdu_pkg.sv
`timescale 1ns/1ps
package mdu_pkg;

  typedef enum logic [1:0] {
    OP_MULS = 2'b00,
    OP_MULU = 2'b01,
    OP_DIVS = 2'b10,
    OP_DIVU = 2'b11
  } mdOp_e;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic load;   // capture raw operands and opcode
    logic setup;  // form magnitudes and sign fix-up flags
    logic step;   // one shift-add / restoring iteration
    logic last;   // final iteration: commit HI/LO
  } mdCtl_t;

endpackage

// File: rtl/mdu_ctrl.sv
`timescale 1ns/1ps
module mdu_ctrl
  import mdu_pkg::*;
#(
  parameter int ITER = 32
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   startValid,
  output mdCtl_t ctl,
  output logic   busy
);

  localparam int CW = (ITER > 1) ? $clog2(ITER) : 1;
  localparam int LW = $clog2(ITER + 2) + 1;

  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_RUN} st_e;

  st_e           state;
  logic [CW-1:0] iterCnt;

  always_comb begin
    ctl.load  = (state == ST_IDLE) && startValid;
    ctl.setup = (state == ST_SETUP);
    ctl.step  = (state == ST_RUN);
    ctl.last  = (state == ST_RUN) && (iterCnt == CW'(ITER - 1));
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      iterCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE:  if (ctl.load) state <= ST_SETUP;
        ST_SETUP: begin
          state   <= ST_RUN;
          iterCnt <= '0;
        end
        ST_RUN: begin
          iterCnt <= iterCnt + 1'b1;
          if (ctl.last) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // window counter for the busy-length check
  logic [LW-1:0] busyLen;
  always_ff @(posedge clk) begin
    if (!rstN)     busyLen <= '0;
    else if (busy) busyLen <= busyLen + 1'b1;
    else           busyLen <= '0;
  end

  // R5
  busy_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyLen == LW'(ITER + 1)));

  // R5
  last_ends_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.last |=> !busy);

endmodule

// File: rtl/mdu_dpath.sv
`timescale 1ns/1ps
module mdu_dpath
  import mdu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  mdCtl_t       ctl,
  input  mdOp_e        startOp,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic [W-1:0] hiReg,
  output logic [W-1:0] loReg
);

  localparam int W2 = 2 * W;

  // captured request
  logic [W-1:0] rawA, rawB;
  mdOp_e        rawOp;

  // working state
  logic [W-1:0] mcand;   // multiplicand or divisor magnitude
  logic [W-1:0] accHi;   // partial product high / partial remainder
  logic [W-1:0] accLo;   // multiplier bits / quotient bits
  logic         negHi, negLo, isDiv;

  // setup decode
  logic         isSigned, sA, sB, bZero;
  logic [W-1:0] magA, magB;

  always_comb begin
    isSigned = ~rawOp[0];
    sA       = isSigned & rawA[W-1];
    sB       = isSigned & rawB[W-1];
    magA     = sA ? (~rawA + 1'b1) : rawA;
    magB     = sB ? (~rawB + 1'b1) : rawB;
    bZero    = (rawB == '0);
  end

  // one multiply iteration
  logic [W:0]   mulSum;
  logic [W-1:0] mulHi, mulLo;
  always_comb begin
    mulSum = {1'b0, accHi} + (accLo[0] ? {1'b0, mcand} : '0);
    mulHi  = mulSum[W:1];
    mulLo  = {mulSum[0], accLo[W-1:1]};
  end

  // one restoring-division iteration
  logic [W:0]   divShift;
  logic [W+1:0] divDiff;
  logic         divTake;
  logic [W-1:0] divHi, divLo;
  always_comb begin
    divShift = {accHi, accLo[W-1]};
    divDiff  = {1'b0, divShift} - {2'b00, mcand};
    divTake  = ~divDiff[W+1];
    divHi    = divTake ? divDiff[W-1:0] : divShift[W-1:0];
    divLo    = {accLo[W-2:0], divTake};
  end

  logic [W-1:0]  nextHi, nextLo;
  logic [W2-1:0] prodFix;
  logic [W-1:0]  finHi, finLo;
  always_comb begin
    nextHi  = isDiv ? divHi : mulHi;
    nextLo  = isDiv ? divLo : mulLo;
    prodFix = negHi ? (~{nextHi, nextLo} + 1'b1) : {nextHi, nextLo};
    if (isDiv) begin
      finHi = negHi ? (~nextHi + 1'b1) : nextHi;
      finLo = negLo ? (~nextLo + 1'b1) : nextLo;
    end else begin
      finHi = prodFix[W2-1:W];
      finLo = prodFix[W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rawA  <= '0;
      rawB  <= '0;
      rawOp <= OP_MULS;
      mcand <= '0;
      accHi <= '0;
      accLo <= '0;
      negHi <= 1'b0;
      negLo <= 1'b0;
      isDiv <= 1'b0;
      hiReg <= '0;
      loReg <= '0;
    end else begin
      if (ctl.load) begin
        rawA  <= opA;
        rawB  <= opB;
        rawOp <= startOp;
      end
      if (ctl.setup) begin
        isDiv <= rawOp[1];
        accHi <= '0;
        if (rawOp[1]) begin
          mcand <= magB;
          accLo <= magA;
          negHi <= sA;
          negLo <= (sA ^ sB) & ~bZero;
        end else begin
          mcand <= magA;
          accLo <= magB;
          negHi <= sA ^ sB;
          negLo <= sA ^ sB;
        end
      end
      if (ctl.step) begin
        accHi <= nextHi;
        accLo <= nextLo;
      end
      if (ctl.last) begin
        hiReg <= finHi;
        loReg <= finLo;
      end
    end
  end

  // R8
  hilo_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.last |=> ($stable(hiReg) && $stable(loReg)));

  // R6
  raw_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> ($stable(rawA) && $stable(rawB) && $stable(rawOp)));

  // R7
  div_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.last && isDiv && bZero) |=> ((loReg == '1) && (hiReg == $past(rawA))));

endmodule

// File: rtl/muldiv_hilo.sv
`timescale 1ns/1ps
module muldiv_hilo
  import mdu_pkg::*;
#(
  parameter int W    = 32,
  parameter int ITER = W
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         startValid,
  input  logic [1:0]   startOp,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic         busy,
  input  logic         hiRdReq,
  input  logic         loRdReq,
  output logic [W-1:0] hiRdData,
  output logic [W-1:0] loRdData,
  output logic         hiRdStall,
  output logic         loRdStall
);

  mdCtl_t ctl;
  logic   busyInt;

  mdu_ctrl #(.ITER(ITER)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startValid (startValid),
    .ctl        (ctl),
    .busy       (busyInt)
  );

  mdu_dpath #(.W(W)) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .startOp (mdOp_e'(startOp)),
    .opA     (opA),
    .opB     (opB),
    .hiReg   (hiRdData),
    .loReg   (loRdData)
  );

  assign busy      = busyInt;
  assign hiRdStall = hiRdReq & busyInt;
  assign loRdStall = loRdReq & busyInt;

  // R5
  start_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startValid && !busy) |=> busy);

  // R9
  rd_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (!hiRdStall && !loRdStall));

endmodule

// File: tb/sim_muldiv_hilo.sv
`timescale 1ns/1ps
module sim_muldiv_hilo;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startValid = 1'b0;
  logic [1:0]  startOp = 2'b00;
  logic [31:0] opA = '0, opB = '0;
  logic        hiRdReq = 1'b0, loRdReq = 1'b0;
  logic        busy, hiRdStall, loRdStall;
  logic [31:0] hiRdData, loRdData;

  int compared = 0;
  int mismatched = 0;

  always #2.5 clk = ~clk;

  muldiv_hilo u0 (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startOp(startOp),
    .opA(opA), .opB(opB), .busy(busy), .hiRdReq(hiRdReq), .loRdReq(loRdReq),
    .hiRdData(hiRdData), .loRdData(loRdData),
    .hiRdStall(hiRdStall), .loRdStall(loRdStall)
  );

  // ---------------- reference model ----------------
  int          mCnt = 0;
  logic [31:0] mHi = '0, mLo = '0, pendHi = '0, pendLo = '0;
  string       mTag = "R8";
  string       pendTag = "R8";

  task automatic refCompute(input logic [1:0] op, input logic [31:0] a,
                            input logic [31:0] b);
    logic signed [63:0] sp;
    logic [63:0]        up;
    longint             sa, sb, q, r;
    case (op)
      2'b00: begin
        sp = $signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b});
        pendHi = sp[63:32]; pendLo = sp[31:0]; pendTag = "R1";
      end
      2'b01: begin
        up = {32'b0, a} * {32'b0, b};
        pendHi = up[63:32]; pendLo = up[31:0]; pendTag = "R2";
      end
      default: begin
        if (b == 32'd0) begin
          pendHi = a; pendLo = 32'hFFFF_FFFF; pendTag = "R7";
        end else if (op == 2'b10) begin
          sa = longint'($signed(a)); sb = longint'($signed(b));
          q = sa / sb; r = sa % sb;
          pendHi = r[31:0]; pendLo = q[31:0]; pendTag = "R3";
        end else begin
          pendHi = a % b; pendLo = a / b; pendTag = "R4";
        end
      end
    endcase
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 0; mHi = '0; mLo = '0; mTag = "R8";
    end else if (mCnt == 0) begin
      if (startValid) begin
        refCompute(startOp, opA, opB);
        mCnt = 33;
      end
    end else begin
      mCnt = mCnt - 1;
      if (mCnt == 0) begin
        mHi = pendHi; mLo = pendLo; mTag = pendTag;
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare every cycle, away from the rising edge
  always @(negedge clk) begin
    if (rstN) begin
      check("R5 R6 busy", {31'b0, busy}, {31'b0, (mCnt > 0)});
      check({mTag, " R8 HI"}, hiRdData, mHi);
      check({mTag, " R8 LO"}, loRdData, mLo);
      check("R9 hiStall", {31'b0, hiRdStall}, {31'b0, hiRdReq && (mCnt > 0)});
      check("R9 loStall", {31'b0, loRdStall}, {31'b0, loRdReq && (mCnt > 0)});
    end
  end

  // random read traffic
  initial begin
    forever begin
      @(posedge clk); #1;
      hiRdReq = $urandom_range(0, 1) == 1;
      loRdReq = $urandom_range(0, 1) == 1;
    end
  end

  task automatic issue(input logic [1:0] op, input logic [31:0] a,
                       input logic [31:0] b, input bit poke);
    @(posedge clk); #1;
    while (busy) begin @(posedge clk); #1; end
    startValid = 1'b1; startOp = op; opA = a; opB = b;
    @(posedge clk); #1;
    startValid = 1'b0; opA = $urandom; opB = $urandom;
    if (poke) begin
      // R6: strobe aimed into the busy window
      repeat (4) @(posedge clk);
      #1;
      startValid = 1'b1; startOp = ~op; opA = $urandom; opB = 32'd0;
      @(posedge clk); #1;
      startValid = 1'b0;
    end
  endtask

  // watchdog
  initial begin
    #(5ns * 150000);
    mismatched++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R8: reset state
    check("R8 reset busy", {31'b0, busy}, 32'd0);
    check("R8 reset HI", hiRdData, 32'd0);
    check("R8 reset LO", loRdData, 32'd0);
    rstN = 1'b1;

    issue(2'b00, 32'hFFFF_FFFD, 32'd7, 1'b0);          // R1 -3*7
    issue(2'b00, 32'h8000_0000, 32'h8000_0000, 1'b1);  // R1 min*min, R6
    issue(2'b00, 32'd0, 32'h1234_5678, 1'b0);          // R1 zero
    issue(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);  // R2 max*max
    issue(2'b01, 32'h0001_0000, 32'h0001_0000, 1'b1);  // R2 carry into HI
    issue(2'b10, 32'hFFFF_FFF9, 32'd2, 1'b0);          // R3 -7/2
    issue(2'b10, 32'd7, 32'hFFFF_FFFE, 1'b0);          // R3 7/-2
    issue(2'b10, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0);  // R3 min/-1
    issue(2'b10, 32'hFFFF_FFF0, 32'hFFFF_FFFC, 1'b1);  // R3 both negative
    issue(2'b11, 32'd100, 32'd7, 1'b0);                // R4
    issue(2'b11, 32'hFFFF_FFFF, 32'd1, 1'b0);          // R4 divisor one
    issue(2'b11, 32'd3, 32'hFFFF_FFFF, 1'b0);          // R4 quotient zero
    issue(2'b10, 32'hFFFF_FFFB, 32'd0, 1'b0);          // R7 signed by zero
    issue(2'b11, 32'd123, 32'd0, 1'b1);                // R7 unsigned by zero
    for (int i = 0; i < 40; i++) begin
      issue(2'($urandom_range(0, 3)), $urandom, $urandom, (i % 5) == 0);
    end
    @(posedge clk); #1;
    while (busy) begin @(posedge clk); #1; end
    repeat (4) @(posedge clk);
    #1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule